// File: doc/BRIEF.md
# Supply Monitor Backup Sequencer

This block turns three digitised supply-voltage comparator flags into the control signals that protect a battery-backed memory. One flag is high while the supply is above the full-operation level. One is high while it is above the write-protect trip level. The third is high while it is above the lower level at which the memory's supply moves between the external rail and the backup cell. Each flag is asynchronous, so it passes through a two-flop synchroniser and a debounce filter before a five-state sequencer acts on it.

The sequencer opens the memory for writes only when the supply is healthy. Every other state holds write protection. The backup source is selected only while the supply is below the switchover level. A one-time seal bit keeps the backup cell disconnected from delivery until the supply first reaches the trip level. After that the seal stays cleared across ordinary resets. Only a dedicated factory-reset input can set it again. While the seal is still set and the supply is below the switchover level, the block reports that memory contents are being lost.

Top module: `supply_backup_seq`

## Requirements
- R1: After factoryReset, the outputs read sealed=1, writeProtect=1, ready=0 and backupSelect=0.
- R2: A comparator flag (bit 0 = above switchover, bit 1 = above trip, bit 2 = above operating level) is acted on only once its synchronised value has differed from the filtered value for DEBOUNCE_CYCLES consecutive clocks. A shorter pulse leaves every output unchanged.
- R3: ready is 1 only in the healthy state, which is entered from recovery when the filtered operating-level flag is 1. writeProtect is always the inverse of ready.
- R4: The seal clears on the first clock where the filtered trip flag is 1 while the seal is set. The sequencer then enters recovery.
- R5: An ordinary reset (rstN low) leaves the seal unchanged. Only factoryReset sets it.
- R6: While the seal is set, backupSelect is 0 whatever the flags are.
- R7: With the seal cleared, backupSelect becomes 1 when the filtered switchover flag is 0. It becomes 0 when that flag returns to 1. After an ordinary reset it reads 1 until the flags resolve.
- R8: dataLoss is 1 exactly when the seal is set and the filtered switchover flag is 0.
- R9: After power returns, the trip and switchover flags alone keep the block protected and not ready. ready returns only once the operating-level flag is 1.
- R10: Losing the operating-level flag while ready sets writeProtect on the next clock.
- R11: The one-hot (ONE_HOT=1) and binary (ONE_HOT=0) state encodings give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Ordinary asynchronous reset, active low; seal untouched |
| factoryReset | input | 1 | Asynchronous, active high; sets the seal and resets the sequencer |
| compFlags | input | 3 | Raw comparator flags: bit 0 switchover, bit 1 trip, bit 2 operating level |
| writeProtect | output | 1 | Memory writes blocked |
| backupSelect | output | 1 | Backup cell supplies the memory |
| ready | output | 1 | Normal operation permitted |
| dataLoss | output | 1 | Seal still set and supply below switchover |
| sealed | output | 1 | Seal bit state |

## Verification
The assertions assume that factoryReset is pulsed once before use, so the seal holds a defined value. They do not assume the flags are ordered the way physical thresholds would order them. Every property is stated against the filtered levels and the outputs, so inconsistent flag combinations are covered. The stimulus asserts factory reset at time zero and holds each flag pattern far longer than the filter window, except for one deliberately short trip pulse. It walks the supply up, down, through an ordinary reset, and through a second factory reset with the supply already high.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int NUM_FLAGS  = 3;
  localparam int NUM_STATES = 5;
  localparam int FLAG_SW    = 0;
  localparam int FLAG_TRIP  = 1;
  localparam int FLAG_RUN   = 2;

  typedef enum logic [2:0] {
    ST_SEALED     = 3'd0,
    ST_POWERED_OK = 3'd1,
    ST_PROTECTED  = 3'd2,
    ST_ON_BACKUP  = 3'd3,
    ST_RECOVERING = 3'd4
  } state_e;

  // filtered levels and seal, datapath to control
  typedef struct packed {
    logic run;
    logic trip;
    logic sw;
    logic seal;
  } level_t;

  // strobes, control to datapath
  typedef struct packed {
    logic clearSeal;
  } strobe_t;
endpackage

// File: rtl/supmon_debounce.sv
module supmon_debounce #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      cntQ  <= '0;
      dout  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], din};
      if (syncQ[1] == dout) begin
        cntQ <= '0;
      end else if (cntQ == LAST) begin
        dout <= syncQ[1];
        cntQ <= '0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/supmon_cond.sv
module supmon_cond
  import supmon_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 factoryReset,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  strobe_t              strobe,
  output level_t               lvl
);
  logic [NUM_FLAGS-1:0] filtered;
  logic                 sealQ;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    supmon_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk (clk),
      .rstN(rstN),
      .din (rawFlags[i]),
      .dout(filtered[i])
    );
  end

  // seal survives ordinary reset; only the factory input sets it
  always_ff @(posedge clk or posedge factoryReset) begin
    if (factoryReset)         sealQ <= 1'b1;
    else if (strobe.clearSeal) sealQ <= 1'b0;
  end

  always_comb begin
    lvl.run  = filtered[FLAG_RUN];
    lvl.trip = filtered[FLAG_TRIP];
    lvl.sw   = filtered[FLAG_SW];
    lvl.seal = sealQ;
  end
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  level_t  lvl,
  output strobe_t strobe,
  output logic    writeProtect,
  output logic    backupSelect,
  output logic    ready,
  output logic    dataLoss
);
  state_e stCur;
  state_e stNext;

  always_comb begin
    stNext = stCur;
    strobe = '0;
    case (stCur)
      ST_SEALED: begin
        if (!lvl.seal) begin
          stNext = ST_ON_BACKUP;
        end else if (lvl.trip) begin
          strobe.clearSeal = 1'b1;
          stNext = ST_RECOVERING;
        end
      end
      ST_ON_BACKUP:  if (lvl.sw) stNext = ST_RECOVERING;
      ST_RECOVERING: begin
        if (!lvl.sw)      stNext = ST_ON_BACKUP;
        else if (lvl.run) stNext = ST_POWERED_OK;
      end
      ST_POWERED_OK: begin
        if (!lvl.sw)       stNext = ST_ON_BACKUP;
        else if (!lvl.run) stNext = ST_PROTECTED;
      end
      ST_PROTECTED: begin
        if (!lvl.sw)      stNext = ST_ON_BACKUP;
        else if (lvl.run) stNext = ST_POWERED_OK;
      end
      default: stNext = ST_SEALED;
    endcase
  end

  if (ONE_HOT) begin : g_onehot
    logic [NUM_STATES-1:0] ohQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ohQ <= NUM_STATES'(1) << ST_SEALED;
      else       ohQ <= NUM_STATES'(1) << stNext;
    end
    always_comb begin
      stCur = ST_SEALED;
      for (int i = 0; i < NUM_STATES; i++) begin
        if (ohQ[i]) stCur = state_e'(3'(i));
      end
    end
  end else begin : g_binary
    state_e binQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) binQ <= ST_SEALED;
      else       binQ <= stNext;
    end
    assign stCur = binQ;
  end

  always_comb begin
    ready        = (stCur == ST_POWERED_OK);
    writeProtect = (stCur != ST_POWERED_OK);
    backupSelect = (stCur == ST_ON_BACKUP) || ((stCur == ST_SEALED) && !lvl.seal);
    dataLoss     = lvl.seal && !lvl.sw;
  end
endmodule

// File: rtl/supply_backup_seq.sv
module supply_backup_seq
  import supmon_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 16,
  parameter bit ONE_HOT         = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 factoryReset,
  input  logic [NUM_FLAGS-1:0] compFlags,
  output logic                 writeProtect,
  output logic                 backupSelect,
  output logic                 ready,
  output logic                 dataLoss,
  output logic                 sealed
);
  level_t  lvl;
  strobe_t strobe;
  logic    coreRstN;

  assign coreRstN = rstN & ~factoryReset;

  supmon_cond #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_cond (
    .clk         (clk),
    .rstN        (coreRstN),
    .factoryReset(factoryReset),
    .rawFlags    (compFlags),
    .strobe      (strobe),
    .lvl         (lvl)
  );

  supmon_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
    .clk         (clk),
    .rstN        (coreRstN),
    .lvl         (lvl),
    .strobe      (strobe),
    .writeProtect(writeProtect),
    .backupSelect(backupSelect),
    .ready       (ready),
    .dataLoss    (dataLoss)
  );

  assign sealed = lvl.seal;
endmodule

// File: rtl/supply_backup_seq_chk.sv
module supply_backup_seq_chk
  import supmon_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   factoryReset,
  input level_t lvl,
  input logic   writeProtect,
  input logic   backupSelect,
  input logic   ready,
  input logic   dataLoss,
  input logic   sealed
);
  p_ready_after_run_r3: assert property (@(posedge clk) disable iff (!rstN || factoryReset)
    $rose(ready) |-> $past(lvl.run));

  p_drop_protect_r10: assert property (@(posedge clk) disable iff (!rstN || factoryReset)
    ready && !lvl.run |=> writeProtect);

  p_seal_clear_trip_r4: assert property (@(posedge clk) disable iff (factoryReset)
    $fell(sealed) |-> $past(lvl.trip));

  p_seal_sticky_r5: assert property (@(posedge clk) disable iff (factoryReset)
    !$past(sealed) |-> !sealed);

  p_seal_no_backup_r6: assert property (@(posedge clk) disable iff (!rstN || factoryReset)
    sealed |-> !backupSelect);

  p_backup_on_low_r7: assert property (@(posedge clk) disable iff (!rstN || factoryReset)
    $rose(backupSelect) |-> !$past(lvl.sw));

  p_loss_needs_seal_r8: assert property (@(posedge clk) disable iff (!rstN || factoryReset)
    dataLoss |-> sealed);
endmodule

bind supply_backup_seq supply_backup_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .factoryReset(factoryReset),
  .lvl         (lvl),
  .writeProtect(writeProtect),
  .backupSelect(backupSelect),
  .ready       (ready),
  .dataLoss    (dataLoss),
  .sealed      (sealed)
);

// File: tb/supply_backup_seq_bench.sv
module supply_backup_seq_bench;
  localparam int DEB = 4;
  localparam int M_SEALED = 0, M_OK = 1, M_PROT = 2, M_BACKUP = 3, M_RECOV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       facRst = 1'b0;
  logic [2:0] flags = 3'b000;
  logic       started = 1'b0;

  logic wpA, bsA, rdA, dlA, seA;
  logic wpB, bsB, rdB, dlB, seB;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  supply_backup_seq #(.DEBOUNCE_CYCLES(DEB), .ONE_HOT(1'b1)) u_supply_backup_seq (
    .clk(clk), .rstN(rstN), .factoryReset(facRst), .compFlags(flags),
    .writeProtect(wpA), .backupSelect(bsA), .ready(rdA), .dataLoss(dlA), .sealed(seA));

  supply_backup_seq #(.DEBOUNCE_CYCLES(DEB), .ONE_HOT(1'b0)) u_supply_backup_seq_bin (
    .clk(clk), .rstN(rstN), .factoryReset(facRst), .compFlags(flags),
    .writeProtect(wpB), .backupSelect(bsB), .ready(rdB), .dataLoss(dlB), .sealed(seB));

  // behavioural reference
  int s1 [3];
  int s2 [3];
  int q  [3];
  int cnt[3];
  int mSeal = 0;
  int mSt   = M_SEALED;

  task automatic clearPipe();
    for (int i = 0; i < 3; i++) begin
      s1[i] = 0; s2[i] = 0; q[i] = 0; cnt[i] = 0;
    end
    mSt = M_SEALED;
  endtask

  always @(posedge clk or negedge rstN or posedge facRst) begin
    if (facRst) begin
      mSeal = 1;
      clearPipe();
    end else if (!rstN) begin
      clearPipe();
    end else begin
      int oSw, oTrip, oRun, oSeal, nSt;
      oSw = q[0]; oTrip = q[1]; oRun = q[2]; oSeal = mSeal; nSt = mSt;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == q[i]) cnt[i] = 0;
        else if (cnt[i] == DEB - 1) begin q[i] = s2[i]; cnt[i] = 0; end
        else cnt[i] = cnt[i] + 1;
        s2[i] = s1[i];
        s1[i] = flags[i] ? 1 : 0;
      end
      case (mSt)
        M_SEALED: if (oSeal == 0) nSt = M_BACKUP;
                  else if (oTrip != 0) begin mSeal = 0; nSt = M_RECOV; end
        M_BACKUP: if (oSw != 0) nSt = M_RECOV;
        M_RECOV:  if (oSw == 0) nSt = M_BACKUP; else if (oRun != 0) nSt = M_OK;
        M_OK:     if (oSw == 0) nSt = M_BACKUP; else if (oRun == 0) nSt = M_PROT;
        M_PROT:   if (oSw == 0) nSt = M_BACKUP; else if (oRun != 0) nSt = M_OK;
        default:  nSt = M_SEALED;
      endcase
      mSt = nSt;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started) begin
      logic eRd, eBs, eDl, eSe;
      eRd = (mSt == M_OK);
      eBs = (mSt == M_BACKUP) || (mSt == M_SEALED && mSeal == 0);
      eSe = (mSeal != 0);
      eDl = eSe && (q[0] == 0);
      chk("R3", "ready", rdA, eRd);
      chk("R3", "writeProtect", wpA, !eRd);
      chk("R7", "backupSelect", bsA, eBs);
      chk("R8", "dataLoss", dlA, eDl);
      chk("R4", "sealed", seA, eSe);
      chk("R11", "bin ready", rdB, eRd);
      chk("R11", "bin writeProtect", wpB, !eRd);
      chk("R11", "bin backupSelect", bsB, eBs);
      chk("R11", "bin dataLoss", dlB, eDl);
      chk("R11", "bin sealed", seB, eSe);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic setFlags(input logic [2:0] v);
    @(negedge clk);
    flags = v;
  endtask

  initial begin
    #1 facRst = 1'b1;
    started = 1'b1;
    waitCyc(2);
    @(negedge clk); facRst = 1'b0; rstN = 1'b1;
    waitCyc(1);
    chk("R1", "sealed after factory reset", seA, 1'b1);
    chk("R1", "writeProtect after factory reset", wpA, 1'b1);
    chk("R1", "ready after factory reset", rdA, 1'b0);
    chk("R1", "backupSelect after factory reset", bsA, 1'b0);
    chk("R8", "dataLoss sealed and low", dlA, 1'b1);

    setFlags(3'b001); waitCyc(20);
    chk("R6", "no backup while sealed", bsA, 1'b0);
    chk("R8", "no loss above switchover", dlA, 1'b0);

    setFlags(3'b011); repeat (2) @(negedge clk); flags = 3'b001;
    waitCyc(20);
    chk("R2", "short trip pulse ignored", seA, 1'b1);

    setFlags(3'b111); waitCyc(20);
    chk("R4", "seal cleared at trip", seA, 1'b0);
    chk("R3", "ready when healthy", rdA, 1'b1);
    chk("R3", "writes open", wpA, 1'b0);

    setFlags(3'b011); waitCyc(20);
    chk("R10", "protect on loss of run", wpA, 1'b1);
    chk("R10", "not ready", rdA, 1'b0);

    setFlags(3'b001); waitCyc(20);
    chk("R7", "no backup above switchover", bsA, 1'b0);
    setFlags(3'b000); waitCyc(20);
    chk("R7", "backup below switchover", bsA, 1'b1);
    chk("R8", "no loss once unsealed", dlA, 1'b0);

    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    chk("R5", "seal kept during reset", seA, 1'b0);
    @(negedge clk); rstN = 1'b1;
    waitCyc(5);
    chk("R5", "seal kept after reset", seA, 1'b0);
    chk("R7", "backup after reset", bsA, 1'b1);

    setFlags(3'b011); waitCyc(20);
    chk("R9", "trip alone not ready", rdA, 1'b0);
    chk("R9", "trip alone protected", wpA, 1'b1);
    setFlags(3'b111); waitCyc(20);
    chk("R9", "ready after run", rdA, 1'b1);

    setFlags(3'b000); waitCyc(20);
    chk("R7", "fast drop to backup", bsA, 1'b1);
    chk("R10", "fast drop protected", wpA, 1'b1);

    setFlags(3'b111);
    @(negedge clk); facRst = 1'b1;
    waitCyc(2);
    @(negedge clk); facRst = 1'b0;
    waitCyc(2);
    chk("R5", "factory reset sets seal", seA, 1'b1);
    chk("R1", "no backup after factory reset", bsA, 1'b0);
    waitCyc(20);
    chk("R4", "seal clears again", seA, 1'b0);
    chk("R11", "binary ready at end", rdB, 1'b1);

    summary();
    $finish;
  end
endmodule